// File: doc/BRIEF.md
# Coarse/Fine Time-Interval Combiner

This block is the digital back end of a time-interval measurement channel. A coarse counter runs freely on the system clock and is never cleared by a measurement. When a synchronised START strobe arrives, the block records the counter value and the START fine code. When a STOP strobe arrives after that START, it records the counter value and the STOP fine code. One cycle later it reports the full interval in fine-LSB units.

A fine code is the time from its event to the next reference clock edge, given as an integer number of fine LSBs. The interval is therefore the START fine code, plus the number of clock periods between the two capture edges scaled to fine units, minus the STOP fine code. The span is a modular difference of the two captured counter values, so a counter wrap between START and STOP gives the correct result. Each result is marked by a one-cycle valid pulse, and the result word holds its value until the next result.

Top module: `tdc_interval_core`

## Requirements
- R1: While reset is high and after it is released, `out_valid` is 0 and `out_interval` is 0 until a measurement completes.
- R2: The coarse counter advances by one on every clock edge outside reset and wraps modulo 2^CNT_W. START and STOP events never clear it.
- R3: A STOP strobe sampled at edge k while a START is held gives `out_interval` = start_fine + span*FINE_PER_CLK − stop_fine at edge k+1, with `out_valid` high for that one cycle. Here span is the number of clock edges from the START capture edge to edge k.
- R4: The span is the STOP count minus the START count modulo 2^CNT_W, so a counter wrap between the two events gives the true span.
- R5: A STOP strobe with no held START, and no START in the same cycle, produces no pulse and leaves `out_interval` unchanged.
- R6: An accepted STOP releases the held START. A further STOP without a new START is ignored.
- R7: A new START while a START is already held replaces the held count and fine code.
- R8: START and STOP strobes in the same cycle form a pair with span 0, and the result is start_fine − stop_fine.
- R9: If the combined value would be negative, `out_interval` is 0.
- R10: A fine code greater than FINE_PER_CLK is treated as FINE_PER_CLK.
- R11: With the default parameters, a span of 4000 clock periods is reported exactly. This is 20 µs at a 200 MHz reference.
- R12: `out_interval` keeps its last value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (reference) clock |
| rst | input | 1 | Synchronous active-high reset |
| start_stb | input | 1 | Synchronised START event strobe, one cycle |
| start_fine | input | FINE_W | START fine code, fine LSBs to the next clock edge |
| stop_stb | input | 1 | Synchronised STOP event strobe, one cycle |
| stop_fine | input | FINE_W | STOP fine code, fine LSBs to the next clock edge |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_interval | output | CNT_W+clog2(FINE_PER_CLK+1) | Combined interval in fine LSBs |

## Verification
A counter that skipped or stalled, or a held START count that drifted, would show as a result off by a whole multiple of FINE_PER_CLK. This error appears on the first measurement whose span covers the fault, so long spans and a span across the counter wrap are measured. A wrong held-START state shows either as a spurious pulse one cycle after an orphan STOP, or as a missing pulse one cycle after a valid STOP. The pulse timing is therefore sampled in the cycle before, during and after each expected result.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    localparam int unsigned TDC_CNT_W_DEF    = 13;
    localparam int unsigned TDC_FINE_W_DEF   = 9;
    localparam int unsigned TDC_FINE_PER_DEF = 384;

    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_HELD = 1'b1
    } arm_e;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_START = 2'd1,
        EV_STOP  = 2'd2,
        EV_BOTH  = 2'd3
    } ev_e;

    function automatic ev_e classify_ev(input logic start_s, input logic stop_s);
        ev_e e;
        case ({stop_s, start_s})
            2'b01:   e = EV_START;
            2'b10:   e = EV_STOP;
            2'b11:   e = EV_BOTH;
            default: e = EV_NONE;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/tdc_free_counter.sv
module tdc_free_counter #(
    parameter int unsigned CNT_W = tdc_pkg::TDC_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end

    // R2: steps by one every cycle, wrapping naturally
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> count == CNT_W'($past(count) + 1'b1));
endmodule

// File: rtl/tdc_event_capture.sv
module tdc_event_capture
    import tdc_pkg::*;
#(
    parameter int unsigned CNT_W        = TDC_CNT_W_DEF,
    parameter int unsigned FINE_W       = TDC_FINE_W_DEF,
    parameter int unsigned FINE_PER_CLK = TDC_FINE_PER_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  count,
    input  logic              start_stb,
    input  logic [FINE_W-1:0] start_fine,
    input  logic              stop_stb,
    input  logic [FINE_W-1:0] stop_fine,
    output logic              pair_valid,
    output logic [CNT_W-1:0]  start_cnt,
    output logic [FINE_W-1:0] start_fq,
    output logic [CNT_W-1:0]  stop_cnt,
    output logic [FINE_W-1:0] stop_fq
);
    localparam logic [FINE_W-1:0] FINE_MAX = FINE_W'(FINE_PER_CLK);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [FINE_W-1:0] fine;
    } stamp_t;

    arm_e   state;
    ev_e    ev;
    stamp_t start_now, stop_now;
    stamp_t start_q, stop_q;

    function automatic logic [FINE_W-1:0] clamp_fine(input logic [FINE_W-1:0] f);
        return (f > FINE_MAX) ? FINE_MAX : f;
    endfunction

    always_comb begin
        ev             = classify_ev(start_stb, stop_stb);
        start_now.cnt  = count;
        start_now.fine = clamp_fine(start_fine);
        stop_now.cnt   = count;
        stop_now.fine  = clamp_fine(stop_fine);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ARM_IDLE;
            start_q    <= '0;
            stop_q     <= '0;
            pair_valid <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            case (ev)
                EV_START: begin
                    start_q <= start_now;
                    state   <= ARM_HELD;
                end
                EV_STOP: begin
                    if (state == ARM_HELD) begin
                        stop_q     <= stop_now;
                        pair_valid <= 1'b1;
                        state      <= ARM_IDLE;
                    end
                end
                EV_BOTH: begin
                    start_q    <= start_now;
                    stop_q     <= stop_now;
                    pair_valid <= 1'b1;
                    state      <= ARM_IDLE;
                end
                default: ;
            endcase
        end
    end

    assign start_cnt = start_q.cnt;
    assign start_fq  = start_q.fine;
    assign stop_cnt  = stop_q.cnt;
    assign stop_fq   = stop_q.fine;

    // R5: STOP without a held START yields no pair
    p_orphan_stop_r5: assert property (@(posedge clk) disable iff (rst)
        (stop_stb && !start_stb && state == ARM_IDLE) |=> !pair_valid);
    // R6: an accepted pair releases the held START
    p_disarm_r6: assert property (@(posedge clk) disable iff (rst)
        pair_valid |-> state == ARM_IDLE);
    // R7: a lone START leaves the block holding
    p_arm_r7: assert property (@(posedge clk) disable iff (rst)
        (start_stb && !stop_stb) |=> state == ARM_HELD);
    // R7: without a START the held count does not move
    p_start_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !start_stb |=> $stable(start_q));
    // R10: stored fine codes never exceed one period
    p_fine_bound_r10: assert property (@(posedge clk) disable iff (rst)
        pair_valid |-> (start_q.fine <= FINE_MAX && stop_q.fine <= FINE_MAX));
endmodule

// File: rtl/tdc_combiner.sv
module tdc_combiner #(
    parameter int unsigned CNT_W        = tdc_pkg::TDC_CNT_W_DEF,
    parameter int unsigned FINE_W       = tdc_pkg::TDC_FINE_W_DEF,
    parameter int unsigned FINE_PER_CLK = tdc_pkg::TDC_FINE_PER_DEF,
    parameter int unsigned OUT_W        = CNT_W + $clog2(FINE_PER_CLK + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pair_valid,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic [FINE_W-1:0] start_fq,
    input  logic [CNT_W-1:0]  stop_cnt,
    input  logic [FINE_W-1:0] stop_fq,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_interval
);
    localparam int unsigned EXT_W = OUT_W + 1;
    localparam logic [EXT_W-1:0] PER_EXT = EXT_W'(FINE_PER_CLK);
    localparam logic [OUT_W-1:0] RES_MAX = OUT_W'(((2 ** CNT_W) - 1) * FINE_PER_CLK + FINE_PER_CLK);

    logic [CNT_W-1:0] span;
    logic [EXT_W-1:0] plus_part;
    logic [EXT_W-1:0] minus_part;
    logic [EXT_W-1:0] diff;
    logic [OUT_W-1:0] result_d;

    always_comb begin
        span       = stop_cnt - start_cnt;
        plus_part  = EXT_W'(span) * PER_EXT + EXT_W'(start_fq);
        minus_part = EXT_W'(stop_fq);
        diff       = plus_part - minus_part;
        result_d   = (plus_part < minus_part) ? '0 : diff[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_interval <= '0;
        end else begin
            out_valid <= pair_valid;
            if (pair_valid) out_interval <= result_d;
        end
    end

    // R3: a result pulse always follows a captured pair
    p_valid_src_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(pair_valid));
    // R3: result never exceeds the representable bound
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_interval <= RES_MAX);
    // R12: result holds when no pair arrives
    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !pair_valid |=> $stable(out_interval));
endmodule

// File: rtl/tdc_interval_core.sv
module tdc_interval_core #(
    parameter int unsigned CNT_W        = tdc_pkg::TDC_CNT_W_DEF,
    parameter int unsigned FINE_W       = tdc_pkg::TDC_FINE_W_DEF,
    parameter int unsigned FINE_PER_CLK = tdc_pkg::TDC_FINE_PER_DEF,
    parameter int unsigned OUT_W        = CNT_W + $clog2(FINE_PER_CLK + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_stb,
    input  logic [FINE_W-1:0] start_fine,
    input  logic              stop_stb,
    input  logic [FINE_W-1:0] stop_fine,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_interval
);
    logic [CNT_W-1:0]  count;
    logic              pair_valid;
    logic [CNT_W-1:0]  start_cnt, stop_cnt;
    logic [FINE_W-1:0] start_fq, stop_fq;

    tdc_free_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .count (count)
    );

    tdc_event_capture #(
        .CNT_W        (CNT_W),
        .FINE_W       (FINE_W),
        .FINE_PER_CLK (FINE_PER_CLK)
    ) u_cap (
        .clk        (clk),
        .rst        (rst),
        .count      (count),
        .start_stb  (start_stb),
        .start_fine (start_fine),
        .stop_stb   (stop_stb),
        .stop_fine  (stop_fine),
        .pair_valid (pair_valid),
        .start_cnt  (start_cnt),
        .start_fq   (start_fq),
        .stop_cnt   (stop_cnt),
        .stop_fq    (stop_fq)
    );

    tdc_combiner #(
        .CNT_W        (CNT_W),
        .FINE_W       (FINE_W),
        .FINE_PER_CLK (FINE_PER_CLK),
        .OUT_W        (OUT_W)
    ) u_comb (
        .clk          (clk),
        .rst          (rst),
        .pair_valid   (pair_valid),
        .start_cnt    (start_cnt),
        .start_fq     (start_fq),
        .stop_cnt     (stop_cnt),
        .stop_fq      (stop_fq),
        .out_valid    (out_valid),
        .out_interval (out_interval)
    );

    // R1: no pulse without a preceding STOP strobe
    p_pulse_cause_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(stop_stb, 2));
endmodule

// File: tb/sim_tdc_interval_core.sv
module sim_tdc_interval_core;
    localparam int CNT_W  = 13;
    localparam int FINE_W = 9;
    localparam int FPC    = 384;
    localparam int OUT_W  = CNT_W + $clog2(FPC + 1);
    localparam int NV     = 8;

    // columns: start_fine, gap, stop_fine, expected
    localparam int VEC [NV][4] = '{
        '{100,    5,  40,    1980},   // R3 basic
        '{  0,    1, 384,       0},   // R3 extremes cancel
        '{384,    1,   0,     768},   // R3 full fine terms
        '{200,    0,  50,     150},   // R8 same cycle
        '{ 50,    0, 200,       0},   // R9 negative clamps to zero
        '{ 10, 4000, 300, 1535710},   // R11 long interval
        '{500,    3,  10,    1526},   // R10 start fine clamped
        '{  7,    2, 450,     391}    // R10 stop fine clamped
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_stb = 1'b0;
    logic [FINE_W-1:0] start_fine = '0;
    logic              stop_stb = 1'b0;
    logic [FINE_W-1:0] stop_fine = '0;
    logic              out_valid;
    logic [OUT_W-1:0]  out_interval;

    int n_checks = 0;
    int n_fail   = 0;
    int edges    = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    tdc_interval_core u0 (
        .clk          (clk),
        .rst          (rst),
        .start_stb    (start_stb),
        .start_fine   (start_fine),
        .stop_stb     (stop_stb),
        .stop_fine    (stop_fine),
        .out_valid    (out_valid),
        .out_interval (out_interval)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(input int sf, input int gap, input int pf, input int exp, input string req);
        @(negedge clk);
        start_stb  = 1'b1;
        start_fine = FINE_W'(sf);
        if (gap == 0) begin
            stop_stb  = 1'b1;
            stop_fine = FINE_W'(pf);
        end
        @(negedge clk);
        start_stb = 1'b0;
        if (gap > 0) begin
            repeat (gap - 1) @(negedge clk);
            stop_stb  = 1'b1;
            stop_fine = FINE_W'(pf);
            @(negedge clk);
        end
        stop_stb = 1'b0;
        check(out_valid == 1'b0, req, out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b1, req, out_valid, 1);
        check(out_interval == OUT_W'(exp), req, out_interval, exp);
        @(negedge clk);
        check(out_valid == 1'b0, req, out_valid, 0);
        check(out_interval == OUT_W'(exp), "R12", out_interval, exp);
    endtask

    task automatic lone_stop(input int expv, input string req);
        @(negedge clk);
        stop_stb  = 1'b1;
        stop_fine = 9'd17;
        @(negedge clk);
        stop_stb = 1'b0;
        check(out_valid == 1'b0, req, out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b0, req, out_valid, 0);
        check(out_interval == OUT_W'(expv), req, out_interval, expv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", out_valid, 0);
        check(out_interval == '0, "R1", out_interval, 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", out_valid, 0);

        // R5: STOP with nothing held
        lone_stop(0, "R5");

        for (int i = 0; i < NV; i++) begin
            measure(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], $sformatf("vec%0d", i));
        end

        // R6: STOP after a completed pair is ignored, result unchanged
        lone_stop(391, "R6");

        // R7: second START replaces the first
        @(negedge clk);
        start_stb  = 1'b1;
        start_fine = 9'd30;
        @(negedge clk);
        start_stb = 1'b0;
        repeat (2) @(negedge clk);
        measure(60, 3, 70, 60 + 3 * FPC - 70, "R7");

        // R4 and R2: span across the counter wrap
        while ((edges % (1 << CNT_W)) != (1 << CNT_W) - 3) @(negedge clk);
        measure(20, 12, 5, 20 + 12 * FPC - 5, "R4");
        measure(1, 9000 % (1 << CNT_W), 0, 1 + (9000 % (1 << CNT_W)) * FPC, "R2");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule